// File: doc/BRIEF.md
# SPI Receive Word Packer

This block sits on the receive side of an SPI master port. While chip select is low it samples the serial input line on the configured SPI clock edge and builds bytes, most significant bit first. Every completed byte must be paid for by a strobe from the transmit side, so the receiver never takes in more bytes than were sent. Accepted bytes are packed into 32-bit words, with the first byte in the top lane. A full word of four bytes is written into a receive FIFO through a plain write port.

A transfer often ends with fewer than four bytes collected. Two programmable timeouts then push such a partial word out. The inter-byte gap timer restarts on every accepted byte. The buffer timer starts with the first byte of a partial word. When either timer runs out, the remaining bytes go out with a valid-byte count and with the unused lanes zero-filled. If the FIFO is full, the pending word is held until space frees up. A byte that completes while a word is held is dropped and raises a sticky overflow flag.

All SPI inputs are expected to be synchronous to `clk`, and the SPI clock is oversampled. The timer settings are counted in `clk` cycles.

Top module: `spi_rx_word_packer`

## Requirements
- R1: Bits are sampled only while `spi_csn` is low. With `cpha`=0 a bit is sampled on a rising edge of `spi_sck`, and with `cpha`=1 on a falling edge. Driving `spi_csn` high discards any partly received byte, and edges seen while it is high shift nothing.
- R2: Within a byte the first sampled bit is bit 7. The first byte of a word is placed in `fifo_wdata[31:24]`, the second in [23:16], the third in [15:8] and the fourth in [7:0].
- R3: Each `tx_byte_stb` pulse grants one byte credit. A byte that completes while no credit is outstanding is discarded and never reaches the FIFO.
- R4: When the fourth byte of a word is accepted, one write is made with `fifo_wbytes`=0, which means four valid bytes.
- R5: If the gap setting is G (nonzero), a partial word is written G+2 clock edges after the edge that sampled the last bit of its final byte, provided no further byte arrives. This is the first cycle in which `fifo_wr` is high.
- R6: The buffer timer starts at the first byte of a partial word and later bytes do not restart it. With setting B, the partial word is written B+2 edges after the edge that sampled the last bit of that first byte. Bytes arriving after this flush start a new word.
- R7: On a residual flush `fifo_wbytes` holds the number of valid bytes (1, 2 or 3), and every byte lane above that count reads zero.
- R8: A timer setting of 0 disables that timer. A partial word stays held until a nonzero setting lets a timer expire.
- R9: When both timers expire in the same cycle, exactly one write is made. A write is never made with no byte in it.
- R10: While `fifo_full` is high, `fifo_wr` stays low and the pending word is held. The same word is written once `fifo_full` falls.
- R11: A byte that completes while a word is held by `fifo_full` is dropped and sets `overflow`. `overflow` then stays high until reset.
- R12: After reset `fifo_wr` and `overflow` are low, and no byte, credit or partial word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, synchronous to clk |
| spi_csn | input | 1 | SPI enable, active low |
| spi_miso | input | 1 | Serial data in |
| cpha | input | 1 | Sampling edge select: 0 rising, 1 falling |
| tx_byte_stb | input | 1 | One-cycle pulse per byte sent by the transmitter |
| buf_tmo_cfg | input | TMR_W | Buffer timeout in clk cycles, 0 disables it |
| gap_tmo_cfg | input | TMR_W | Inter-byte gap timeout in clk cycles, 0 disables it |
| fifo_full | input | 1 | FIFO cannot take a write |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | Packed word |
| fifo_wbytes | output | 2 | Valid bytes: 0 for four, else 1 to 3 |
| overflow | output | 1 | Sticky flag for a byte lost during a FIFO stall |

## Verification
A table of full four-byte words is sent in both sampling modes with byte values whose bits differ across lanes, so any swap of bit or lane order shows. Short transfers of one to three bytes are then flushed under gap-only, buffer-only, both-equal and disabled timer settings. The exact write cycle is compared against G+2 and B+2, which shows whether the gap timer restarts on each byte and whether the buffer timer restarts at all. Bytes sent without credit, bits clocked with the enable high, and a byte cut short by the enable show that unpaid or aborted input never reaches the FIFO. A FIFO-full stall followed by an extra byte shows that the held word is kept, that the extra byte is dropped and that the overflow flag stays set.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int BYTE_W     = 8;
  localparam int LANES      = 4;
  localparam int WORD_W     = BYTE_W * LANES;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int BIT_IDX_W  = $clog2(BYTE_W);
  localparam int NUM_TMR    = 2;

  typedef logic [BYTE_W-1:0]     byte_t;
  typedef logic [WORD_W-1:0]     word_t;
  typedef logic [LANE_IDX_W-1:0] lane_idx_t;
endpackage

// File: rtl/rxw_bit_shifter.sv
module rxw_bit_shifter
  import rxw_pkg::*;
#(
  parameter int CREDIT_W = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  spi_sck,
  input  logic  spi_csn,
  input  logic  spi_miso,
  input  logic  cpha,
  input  logic  tx_byte_stb,
  output logic  byte_vld,
  output byte_t byte_data
);
  localparam logic [CREDIT_W-1:0] CREDIT_MAX = '1;

  logic                  sck_q;
  logic [BYTE_W-2:0]     shreg_q, shreg_n;
  logic [BIT_IDX_W-1:0]  bitcnt_q, bitcnt_n;
  logic [CREDIT_W-1:0]   credit_q, credit_n;
  logic                  vld_q, vld_n;
  byte_t                 byte_q, byte_n;
  logic                  edge_hit, sample, last_bit, have_credit, grant, spend;

  always_comb begin
    edge_hit    = cpha ? (sck_q & ~spi_sck) : (~sck_q & spi_sck);
    sample      = edge_hit & ~spi_csn;
    last_bit    = sample & (bitcnt_q == BIT_IDX_W'(BYTE_W-1));
    have_credit = (credit_q != '0);
    spend       = last_bit & have_credit;
    grant       = tx_byte_stb & (credit_q != CREDIT_MAX);

    bitcnt_n = bitcnt_q;
    shreg_n  = shreg_q;
    if (spi_csn) begin
      bitcnt_n = '0;
    end else if (sample) begin
      bitcnt_n = bitcnt_q + 1'b1;
      shreg_n  = {shreg_q[BYTE_W-3:0], spi_miso};
    end

    byte_n = byte_q;
    if (last_bit) byte_n = {shreg_q, spi_miso};
    vld_n = spend;

    credit_n = credit_q;
    if (grant && !spend)      credit_n = credit_q + 1'b1;
    else if (!grant && spend) credit_n = credit_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      credit_q <= '0;
      vld_q    <= 1'b0;
      byte_q   <= '0;
    end else begin
      sck_q    <= spi_sck;
      shreg_q  <= shreg_n;
      bitcnt_q <= bitcnt_n;
      credit_q <= credit_n;
      vld_q    <= vld_n;
      byte_q   <= byte_n;
    end
  end

  assign byte_vld  = vld_q;
  assign byte_data = byte_q;

  // R3: a delivered byte was backed by a credit one cycle earlier
  a_r3_byte_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(credit_q) != '0));

  // R1: with the enable high at the previous edge no byte can come out
  a_r1_idle_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_csn) |-> !vld_q);
endmodule

// File: rtl/rxw_timeout.sv
module rxw_timeout #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             clear,
  input  logic [TMR_W-1:0] cfg,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;

  always_comb begin
    cnt_n = cnt_q;
    run_n = run_q;
    if (clear) begin
      cnt_n = '0;
      run_n = 1'b0;
    end else if (restart) begin
      cnt_n = '0;
      run_n = 1'b1;
    end else if (run_q && (cnt_q != '1)) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end

  assign expired = run_q & (cfg != '0) & (cnt_q >= cfg);

  // R9: a cleared timer cannot report expiry in the next cycle
  a_r9_clear_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !expired);
endmodule

// File: rtl/rxw_word_packer.sv
module rxw_word_packer
  import rxw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      byte_vld,
  input  byte_t     byte_data,
  input  logic      flush_req,
  input  logic      fifo_full,
  output logic      fifo_wr,
  output word_t     fifo_wdata,
  output lane_idx_t fifo_wbytes,
  output logic      overflow,
  output logic      gap_restart,
  output logic      buf_start,
  output logic      commit
);
  lane_idx_t cnt_q, cnt_n;
  word_t     lanes_q, lanes_n, lane_word;
  logic      out_vld_q, out_vld_n;
  word_t     out_data_q, out_data_n;
  lane_idx_t out_bytes_q, out_bytes_n;
  logic      ovf_q, ovf_n;
  logic      wr, out_free;

  always_comb begin
    wr       = out_vld_q & ~fifo_full;
    out_free = ~out_vld_q | ~fifo_full;

    lane_word = lanes_q;
    for (int l = 0; l < LANES; l++) begin
      if (cnt_q == LANE_IDX_W'(l)) lane_word[WORD_W-1-l*BYTE_W -: BYTE_W] = byte_data;
    end

    cnt_n       = cnt_q;
    lanes_n     = lanes_q;
    out_vld_n   = out_vld_q & ~wr;
    out_data_n  = out_data_q;
    out_bytes_n = out_bytes_q;
    ovf_n       = ovf_q;
    commit      = 1'b0;
    gap_restart = 1'b0;
    buf_start   = 1'b0;

    if (byte_vld) begin
      if (!out_free) begin
        ovf_n = 1'b1;
      end else if (cnt_q == LANE_IDX_W'(LANES-1)) begin
        out_data_n  = lane_word;
        out_bytes_n = '0;
        out_vld_n   = 1'b1;
        lanes_n     = '0;
        cnt_n       = '0;
        commit      = 1'b1;
      end else begin
        lanes_n     = lane_word;
        cnt_n       = cnt_q + 1'b1;
        gap_restart = 1'b1;
        buf_start   = (cnt_q == '0);
      end
    end else if (flush_req && (cnt_q != '0) && out_free) begin
      out_data_n  = lanes_q;
      out_bytes_n = cnt_q;
      out_vld_n   = 1'b1;
      lanes_n     = '0;
      cnt_n       = '0;
      commit      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      lanes_q     <= '0;
      out_vld_q   <= 1'b0;
      out_data_q  <= '0;
      out_bytes_q <= '0;
      ovf_q       <= 1'b0;
    end else begin
      cnt_q       <= cnt_n;
      lanes_q     <= lanes_n;
      out_vld_q   <= out_vld_n;
      out_data_q  <= out_data_n;
      out_bytes_q <= out_bytes_n;
      ovf_q       <= ovf_n;
    end
  end

  assign fifo_wr     = wr;
  assign fifo_wdata  = out_data_q;
  assign fifo_wbytes = out_bytes_q;
  assign overflow    = ovf_q;

  // R10: a stalled word stays pending and unchanged
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_q && fifo_full) |=> (out_vld_q && $stable(out_data_q) && $stable(out_bytes_q)));

  // R11: the overflow flag never drops without reset
  a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7: lanes above the valid count read zero on a residual write
  a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && (fifo_wbytes != '0)) |->
      ((fifo_wdata << (BYTE_W * int'(fifo_wbytes))) == '0));

  // R9: a flush is only taken from a non-empty partial word
  a_r9_no_empty_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !byte_vld) |-> (cnt_q != '0));
endmodule

// File: rtl/spi_rx_word_packer.sv
module spi_rx_word_packer
  import rxw_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int CREDIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_miso,
  input  logic              cpha,
  input  logic              tx_byte_stb,
  input  logic [TMR_W-1:0]  buf_tmo_cfg,
  input  logic [TMR_W-1:0]  gap_tmo_cfg,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic [1:0]        fifo_wbytes,
  output logic              overflow
);
  localparam int TMR_GAP = 0;
  localparam int TMR_BUF = 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             byte_vld;
  byte_t            byte_data;
  logic             gap_restart, buf_start, commit;
  logic [NUM_TMR-1:0] tmr_restart, tmr_exp;
  logic [TMR_W-1:0] tmr_cfg [NUM_TMR];
  lane_idx_t        wbytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rxw_bit_shifter #(.CREDIT_W(CREDIT_W)) i_shifter (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .spi_sck     (spi_sck),
    .spi_csn     (spi_csn),
    .spi_miso    (spi_miso),
    .cpha        (cpha),
    .tx_byte_stb (tx_byte_stb),
    .byte_vld    (byte_vld),
    .byte_data   (byte_data)
  );

  assign tmr_restart[TMR_GAP] = gap_restart;
  assign tmr_restart[TMR_BUF] = buf_start;
  assign tmr_cfg[TMR_GAP]     = gap_tmo_cfg;
  assign tmr_cfg[TMR_BUF]     = buf_tmo_cfg;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    rxw_timeout #(.TMR_W(TMR_W)) i_tmr (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .restart (tmr_restart[t]),
      .clear   (commit),
      .cfg     (tmr_cfg[t]),
      .expired (tmr_exp[t])
    );
  end

  rxw_word_packer i_packer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .byte_vld    (byte_vld),
    .byte_data   (byte_data),
    .flush_req   (|tmr_exp),
    .fifo_full   (fifo_full),
    .fifo_wr     (fifo_wr),
    .fifo_wdata  (fifo_wdata),
    .fifo_wbytes (wbytes),
    .overflow    (overflow),
    .gap_restart (gap_restart),
    .buf_start   (buf_start),
    .commit      (commit)
  );

  assign fifo_wbytes = 2'(wbytes);

  // R12: nothing is written while the block is held in reset
  a_r12_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> (!fifo_wr && !overflow));
endmodule

// File: tb/test_spi_rx_word_packer.sv
`timescale 1ns/1ps
module test_spi_rx_word_packer;
  localparam int TMR_W = 16;

  logic clk, rst_n, spi_sck, spi_csn, spi_miso, cpha, tx_byte_stb, fifo_full;
  logic [TMR_W-1:0] buf_tmo_cfg, gap_tmo_cfg;
  logic fifo_wr, overflow;
  logic [31:0] fifo_wdata;
  logic [1:0]  fifo_wbytes;

  spi_rx_word_packer #(.TMR_W(TMR_W), .CREDIT_W(4)) i_spi_rx_word_packer (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_miso(spi_miso), .cpha(cpha), .tx_byte_stb(tx_byte_stb),
    .buf_tmo_cfg(buf_tmo_cfg), .gap_tmo_cfg(gap_tmo_cfg), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_wbytes(fifo_wbytes),
    .overflow(overflow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, wr_total = 0, last_p0 = 0;
  logic [31:0] cap_data [32];
  logic [1:0]  cap_bytes [32];
  int          cap_cyc [32];

  always @(posedge clk) cyc = cyc + 1;

  always begin
    @(negedge clk); #1;
    if (fifo_wr === 1'b1) begin
      cap_data[wr_total % 32]  = fifo_wdata;
      cap_bytes[wr_total % 32] = fifo_wbytes;
      cap_cyc[wr_total % 32]   = cyc;
      wr_total = wr_total + 1;
    end
  end

  // {cpha, four bytes of the word, first byte in the top lane}
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 32'hA5_3C_0F_F0},
    {1'b1, 32'h81_7E_C3_18},
    {1'b0, 32'h01_80_FF_00},
    {1'b1, 32'h6D_B2_49_E7}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); spi_sck = 1'b0;
    idle(2);
    cpha = m;
    idle(1);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input bit stb);
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk);
      spi_sck = cpha ? 1'b1 : 1'b0;
      spi_miso = b[i];
      tx_byte_stb = (i == 7) && stb;
      @(negedge clk);
      tx_byte_stb = 1'b0;
      spi_sck = cpha ? 1'b0 : 1'b1;
    end
    last_p0 = cyc + 1;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stb);
    send_bits(b, 8, stb);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
  endtask

  initial begin
    int base, f0;
    rst_n = 1'b0; spi_sck = 1'b0; spi_csn = 1'b0; spi_miso = 1'b0; cpha = 1'b0;
    tx_byte_stb = 1'b0; fifo_full = 1'b0; buf_tmo_cfg = '0; gap_tmo_cfg = '0;
    idle(4);
    rst_n = 1'b1;
    idle(5);

    // R12 reset state
    chk("R12", "fifo_wr after reset", fifo_wr, 0);
    chk("R12", "overflow after reset", overflow, 0);

    // R2 R4 R1: table of full words in both sampling modes
    for (int v = 0; v < 4; v++) begin
      base = wr_total;
      set_mode(VEC[v][32]);
      for (int k = 0; k < 4; k++) send_byte(VEC[v][31-8*k -: 8], 1);
      idle(6);
      chk("R4", "word count", wr_total - base, 1);
      chk("R2", "word data", cap_data[base % 32], VEC[v][31:0]);
      chk("R4", "full word byte code", cap_bytes[base % 32], 0);
    end
    set_mode(1'b0);

    // R5 gap latency, single byte
    gap_tmo_cfg = 10; buf_tmo_cfg = 0;
    base = wr_total;
    send_byte(8'hC9, 1);
    idle(30);
    chk("R5", "gap flush count", wr_total - base, 1);
    chk("R5", "gap flush cycle", cap_cyc[base % 32] - last_p0, 12);
    chk("R7", "one byte zero fill", cap_data[base % 32], 32'hC9_00_00_00);
    chk("R7", "one byte count", cap_bytes[base % 32], 1);

    // R5 gap restarts per byte: 4 full + 2 residual at 16-cycle spacing
    gap_tmo_cfg = 20;
    base = wr_total;
    send_byte(8'h11, 1); send_byte(8'h22, 1); send_byte(8'h33, 1);
    send_byte(8'h44, 1); send_byte(8'h55, 1); send_byte(8'h66, 1);
    idle(40);
    chk("R5", "gap restart writes", wr_total - base, 2);
    chk("R4", "gap full word", cap_data[base % 32], 32'h11223344);
    chk("R7", "two byte residual", cap_data[(base+1) % 32], 32'h5566_0000);
    chk("R7", "two byte count", cap_bytes[(base+1) % 32], 2);
    chk("R5", "gap residual cycle", cap_cyc[(base+1) % 32] - last_p0, 22);

    // R6 buffer timer not restarted by later bytes
    gap_tmo_cfg = 0; buf_tmo_cfg = 40;
    base = wr_total;
    send_byte(8'hA1, 1); f0 = last_p0;
    send_byte(8'hB2, 1); send_byte(8'hC3, 1); send_byte(8'hD4, 1);
    idle(60);
    chk("R6", "buffer writes", wr_total - base, 2);
    chk("R6", "buffer flush cycle", cap_cyc[base % 32] - f0, 42);
    chk("R7", "three byte residual", cap_data[base % 32], 32'hA1B2C3_00);
    chk("R7", "three byte count", cap_bytes[base % 32], 3);
    chk("R6", "new word after flush", cap_data[(base+1) % 32], 32'hD4_000000);

    // R8 both disabled holds the partial word
    gap_tmo_cfg = 0; buf_tmo_cfg = 0;
    base = wr_total;
    send_byte(8'h5A, 1);
    idle(200);
    chk("R8", "no write while disabled", wr_total - base, 0);
    gap_tmo_cfg = 5;
    idle(10);
    chk("R8", "write once enabled", wr_total - base, 1);
    chk("R8", "held byte data", cap_data[base % 32], 32'h5A_000000);

    // R9 both timers equal: single write
    gap_tmo_cfg = 10; buf_tmo_cfg = 10;
    base = wr_total;
    send_byte(8'h3E, 1);
    idle(80);
    chk("R9", "single write on joint expiry", wr_total - base, 1);
    chk("R9", "joint expiry count", cap_bytes[base % 32], 1);

    // R3 byte without credit is discarded
    gap_tmo_cfg = 5; buf_tmo_cfg = 0;
    base = wr_total;
    send_byte(8'hEE, 0);
    idle(60);
    chk("R3", "uncredited byte ignored", wr_total - base, 0);
    send_byte(8'h42, 1);
    idle(20);
    chk("R3", "credited byte written", wr_total - base, 1);
    chk("R3", "credited byte data", cap_data[base % 32], 32'h42_000000);

    // R1 enable high: bits ignored, the strobe credit remains
    base = wr_total;
    @(negedge clk); spi_csn = 1'b1;
    send_byte(8'h99, 1);
    idle(40);
    chk("R1", "no byte while enable high", wr_total - base, 0);
    set_mode(1'b0);
    @(negedge clk); spi_csn = 1'b0;
    send_byte(8'h3C, 0);
    idle(20);
    chk("R1", "leftover credit byte", cap_data[base % 32], 32'h3C_000000);

    // R1 aborted byte is discarded
    base = wr_total;
    send_bits(8'hF0, 4, 1);
    @(negedge clk); spi_csn = 1'b1; spi_sck = 1'b0;
    idle(4);
    spi_csn = 1'b0;
    idle(2);
    send_byte(8'h96, 0);
    idle(20);
    chk("R1", "abort writes", wr_total - base, 1);
    chk("R1", "abort then clean byte", cap_data[base % 32], 32'h96_000000);

    // R10 R11 stall, overflow, sticky flag
    gap_tmo_cfg = 30; buf_tmo_cfg = 0;
    base = wr_total;
    @(negedge clk); fifo_full = 1'b1;
    send_byte(8'h10, 1); send_byte(8'h20, 1); send_byte(8'h30, 1); send_byte(8'h40, 1);
    idle(10);
    chk("R10", "no write while full", wr_total - base, 0);
    chk("R10", "fifo_wr low while full", fifo_wr, 0);
    chk("R11", "no overflow yet", overflow, 0);
    send_byte(8'h50, 1);
    idle(4);
    chk("R11", "overflow set", overflow, 1);
    fifo_full = 1'b0;
    idle(80);
    chk("R10", "held word written once", wr_total - base, 1);
    chk("R10", "held word data", cap_data[base % 32], 32'h10203040);
    chk("R11", "overflow sticky", overflow, 1);

    // R12 reset clears the flag
    do_reset();
    chk("R12", "overflow after second reset", overflow, 0);
    chk("R12", "fifo_wr after second reset", fifo_wr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule